// File: doc/BRIEF.md
# 8-bit ALU with carry, zero, sign and overflow flags

This is the combinational arithmetic and logic unit of a small 8-bit processor. Each cycle it takes two operands, an operation code and the current flag bits. It returns a result, a new flag set and a write enable for each flag. It also returns a write enable for the result, so the register file knows whether to store the value. The compare and bit-test operations set flags only, so their result enable stays low.

Subtraction runs through the same ripple adder as addition. The second operand is inverted and the carry-in is forced to one. The carry flag therefore reads as "no borrow": it is 1 when the first operand is at least the second, unsigned. The single-bit shifts put the bit that falls out into carry. They set overflow when the sign bit changes. The variable rotate leaves carry and overflow alone.

Flags that an operation does not write pass through unchanged from the incoming flags. A caller can therefore use `flags_out` directly, or combine `flags_we` with its own flag register.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` codes: 0 add, 1 subtract, 2 compare, 3 and, 4 or, 5 xor, 6 bit-test, 7 rotate right, 8 shift left, 9 shift right, 10 pass the second operand; codes 11 to 15 are unused.
- R2: Add gives result (a+b) mod 256. C is the carry out of bit 7. V is 1 when the signed sum lies outside -128..127.
- R3: Subtract and compare give result (a-b) mod 256. C is 1 exactly when a >= b unsigned. V is 1 when the signed difference lies outside -128..127.
- R4: `res_we` is high for codes 0, 1, 3, 4, 5, 7, 8, 9 and 10. It is low for compare (2) and bit-test (6).
- R5: Every defined operation writes Z and S. Z is 1 exactly when `result` is zero, and S equals `result` bit 7.
- R6: And, or, xor, bit-test and pass write only Z and S. Bit-test computes a AND b; pass returns b.
- R7: Rotate right moves a right by `opnd_b` modulo 8, the bits leaving bit 0 entering bit 7. It writes only Z and S.
- R8: Shift left gives a<<1 with bit 0 cleared. C takes input bit 7, and V is 1 when result bit 7 differs from input bit 7.
- R9: Shift right gives a>>1 with bit 7 cleared. C takes input bit 0, and V is 1 when result bit 7 differs from input bit 7.
- R10: Flag vectors are ordered [3]=C, [2]=Z, [1]=S, [0]=V. Any flag whose `flags_we` bit is low leaves `flags_out` equal to `flags_in` for that bit.
- R11: Unused codes return `result` equal to `opnd_a`, with all write enables low and `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand; the value shifted or rotated |
| opnd_b | input | 8 | Second operand; rotate amount for code 7 |
| op_sel | input | 4 | Operation code |
| flags_in | input | 4 | Current flags, [3]=C [2]=Z [1]=S [0]=V |
| result | output | 8 | Operation result |
| res_we | output | 1 | Result should be written back |
| flags_out | output | 4 | Updated flags, same order as flags_in |
| flags_we | output | 4 | Per-flag write enable, same order |

## Verification
Immediate assertions check these rules on every input change: unwritten flags pass through, Z and S agree with the result, carry follows the add and no-borrow rules, and logic and rotate codes never enable C or V. Some behaviour only the sweep can show. It covers exact result values for every operand pair, the rotate amount wrapping at 8, the overflow boundaries at -128 and 127, and the unused codes acting as no-ops. The bench walks all sixteen codes over every pair of operands, with the incoming flags varied, and compares each output against arithmetic done in the bench.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int OP_W   = 4;
    localparam int FLAG_N = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_BIT  = 4'd6,
        OP_ROR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_PASS = 4'd10
    } op_e;

    // packed so that bit 3 is carry and bit 0 is overflow
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_PASS = 2'd3
    } logic_mode_e;

    function automatic logic is_defined(input logic [OP_W-1:0] code);
        return code <= OP_PASS;
    endfunction

    function automatic logic uses_adder_sub(input op_e op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

    function automatic logic writes_result(input op_e op);
        return is_defined(op) && (op != OP_CMP) && (op != OP_BIT);
    endfunction

    function automatic logic writes_cv(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) ||
               (op == OP_SHL) || (op == OP_SHR);
    endfunction

    function automatic logic_mode_e logic_mode_of(input op_e op);
        logic_mode_e m;
        case (op)
            OP_OR:   m = LG_OR;
            OP_XOR:  m = LG_XOR;
            OP_PASS: m = LG_PASS;
            default: m = LG_AND;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]   cy;
    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign cy[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
    end

    assign cout = cy[W];
    assign ovf  = cy[W] ^ cy[W-1];

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SH_W
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  rot,
    output logic [W-1:0]  shl,
    output logic [W-1:0]  shr
);
    logic [SW:0][W-1:0] stg;

    assign stg[0] = a;

    // log-depth barrel: stage k rotates right by 2**k when amt[k] is set
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int M = 1 << k;
        assign stg[k+1] = amt[k] ? {stg[k][M-1:0], stg[k][W-1:M]} : stg[k];
    end

    assign rot = stg[SW];
    assign shl = {a[W-2:0], 1'b0};
    assign shr = {1'b0, a[W-1:1]};

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_mode_e  mode,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (mode)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_PASS: y = b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [FLAG_N-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic              res_we,
    output logic [FLAG_N-1:0] flags_out,
    output logic [FLAG_N-1:0] flags_we
);
    op_e              op;
    logic             defined;
    logic [DATA_W-1:0] sum, rot, shl, shr, lgy;
    logic             cout, ovf;
    flags_t           fin, fnew, fwe;
    logic [DATA_W-1:0] res;

    assign op      = op_e'(op_sel);
    assign defined = is_defined(op_sel);
    assign fin     = flags_t'(flags_in);

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a    (opnd_a),
        .b    (opnd_b),
        .sub  (uses_adder_sub(op)),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    alu8_shift #(.W(DATA_W), .SW(SH_W)) u_shift (
        .a   (opnd_a),
        .amt (opnd_b[SH_W-1:0]),
        .rot (rot),
        .shl (shl),
        .shr (shr)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a    (opnd_a),
        .b    (opnd_b),
        .mode (logic_mode_of(op)),
        .y    (lgy)
    );

    always_comb begin
        res    = opnd_a;
        fnew   = fin;
        fnew.c = fin.c;
        fnew.v = fin.v;
        case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                res    = sum;
                fnew.c = cout;
                fnew.v = ovf;
            end
            OP_AND, OP_OR, OP_XOR, OP_BIT, OP_PASS: res = lgy;
            OP_ROR: res = rot;
            OP_SHL: begin
                res    = shl;
                fnew.c = opnd_a[DATA_W-1];
                fnew.v = shl[DATA_W-1] ^ opnd_a[DATA_W-1];
            end
            OP_SHR: begin
                res    = shr;
                fnew.c = opnd_a[0];
                fnew.v = shr[DATA_W-1] ^ opnd_a[DATA_W-1];
            end
            default: res = opnd_a;
        endcase
        fnew.z = ~|res;
        fnew.s = res[DATA_W-1];

        fwe.c = writes_cv(op);
        fwe.v = writes_cv(op);
        fwe.z = defined;
        fwe.s = defined;
    end

    assign result    = res;
    assign res_we    = writes_result(op);
    assign flags_we  = fwe;
    assign flags_out = (fwe & fnew) | (~fwe & fin);

    // ---------------- assertions ----------------
    logic [DATA_W:0] chk_sum;
    assign chk_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

    always_comb begin
        // R10
        pass_through_chk: assert (((flags_out ^ flags_in) & ~flags_we) == '0)
            else $error("unwritten flag changed");
        // R5
        zero_flag_chk: assert (!flags_we[2] || (flags_out[2] == (result == '0)))
            else $error("Z disagrees with result");
        // R5
        sign_flag_chk: assert (!flags_we[1] || (flags_out[1] == result[DATA_W-1]))
            else $error("S disagrees with result");
        // R2
        add_carry_chk: assert (op_sel != OP_ADD || flags_out[3] == chk_sum[DATA_W])
            else $error("add carry wrong");
        // R3
        no_borrow_chk: assert (!(op_sel == OP_SUB || op_sel == OP_CMP) ||
                               (flags_out[3] == (opnd_a >= opnd_b)))
            else $error("subtract carry wrong");
        // R6
        logic_cv_chk: assert (!(op_sel inside {OP_AND, OP_OR, OP_XOR, OP_BIT, OP_PASS, OP_ROR}) ||
                              (flags_we[3] == 1'b0 && flags_we[0] == 1'b0))
            else $error("logic or rotate enabled C/V");
        // R4
        discard_chk: assert (!(op_sel == OP_CMP || op_sel == OP_BIT) || !res_we)
            else $error("compare/bit-test wrote result");
        // R11
        unused_chk: assert (op_sel <= OP_PASS || (flags_we == '0 && !res_we))
            else $error("unused code enabled a write");
    end

endmodule

// File: tb/alu8_core_bench.sv
`timescale 1ns/100ps
module alu8_core_bench;

    logic       clk = 1'b0;
    logic [7:0] a, b;
    logic [3:0] op, fin;
    logic [7:0] result;
    logic       res_we;
    logic [3:0] flags_out, flags_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    alu8_core u_alu8_core (
        .opnd_a    (a),
        .opnd_b    (b),
        .op_sel    (op),
        .flags_in  (fin),
        .result    (result),
        .res_we    (res_we),
        .flags_out (flags_out),
        .flags_we  (flags_we)
    );

    function automatic int sx(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    task automatic model(input int o, input int x, input int y, input int f,
                         output int r, output int rwe, output int fwe,
                         output int fo, output string tag);
        int c, v, sv, n;
        c   = (f >> 3) & 1;
        v   = f & 1;
        r   = x;
        rwe = 0;
        fwe = 0;
        tag = "R11";
        case (o)
            0: begin r = (x + y) & 255; c = (x + y) > 255;
                     sv = sx(x) + sx(y); v = (sv < -128 || sv > 127);
                     rwe = 1; fwe = 15; tag = "R2"; end
            1, 2: begin r = (x - y) & 255; c = (x >= y);
                     sv = sx(x) - sx(y); v = (sv < -128 || sv > 127);
                     rwe = (o == 1); fwe = 15; tag = "R3"; end
            3: begin r = x & y; rwe = 1; fwe = 6; tag = "R6"; end
            4: begin r = x | y; rwe = 1; fwe = 6; tag = "R6"; end
            5: begin r = x ^ y; rwe = 1; fwe = 6; tag = "R6"; end
            6: begin r = x & y; rwe = 0; fwe = 6; tag = "R6"; end
            7: begin n = y % 8; r = ((x >> n) | (x << (8 - n))) & 255;
                     rwe = 1; fwe = 6; tag = "R7"; end
            8: begin r = (x * 2) & 255; c = x / 128;
                     v = (r / 128) != (x / 128); rwe = 1; fwe = 15; tag = "R8"; end
            9: begin r = x / 2; c = x % 2;
                     v = (r / 128) != (x / 128); rwe = 1; fwe = 15; tag = "R9"; end
            10: begin r = y; rwe = 1; fwe = 6; tag = "R6"; end
            default: ;
        endcase
        fo = f;
        if (fwe != 0) begin
            fo = (c << 3) | ((r == 0) << 2) | ((r / 128) << 1) | v;
            if (fwe == 6) fo = (f & 9) | (fo & 6);
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%0d b=%0d fin=%0d actual=%0d expected=%0d",
                     tag, what, op, a, b, fin, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int r, rwe, fwe, fo;
        string tag;
        a = 0; b = 0; op = 0; fin = 0;
        #2.5;
        // idle state with all-zero inputs: add of zeros (R5: Z set)
        check("R5", "idle flags", flags_out, 4'b0100);
        check("R4", "idle res_we", res_we, 1);
        // R1: sweep every code over every operand pair
        for (int o = 0; o < 16; o++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    op  = o[3:0];
                    a   = x[7:0];
                    b   = y[7:0];
                    fin = x[3:0] ^ y[7:4];
                    #0.4;
                    model(o, x, y, int'(fin), r, rwe, fwe, fo, tag);
                    check(tag, "result", result, r);
                    check("R4", "res_we", res_we, rwe);
                    check("R10", "flags_we", flags_we, fwe);
                    check((o <= 10) ? "R5" : "R10", "flags_out", flags_out, fo);
                    #0.6;
                end
            end
        end
        // R3 boundary: 0x80 - 0x01 overflows, C=1
        op = 4'd1; a = 8'h80; b = 8'h01; fin = 0; #0.4;
        check("R3", "boundary flags", flags_out, 4'b1001);
        // R7 wrap: amount 9 acts as 1
        op = 4'd7; a = 8'h01; b = 8'd9; #0.4;
        check("R7", "rotate wrap", result, 8'h80);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule